// File: doc/BRIEF.md
# Card Data FIFO Engine

The block sits between a host that moves 32-bit words and a card data port that moves one byte at a time. A circular word FIFO holds data in either direction. In receive mode, card bytes are packed into words with the first byte in the least significant lane. In transmit mode, FIFO words are split back into bytes with the least significant lane going out first. A byte counter is loaded from a programmed length when a transfer is enabled, and it stops the data flow when it reaches zero.

The host starts a transfer by pulsing the control strobe with the enable and direction inputs set. In transmit mode the host pushes words. In receive mode it pops them. The block raises a sticky end-of-transfer indication when the counter runs out. It turns itself off once the counter is zero and the FIFO has drained. While a transfer is enabled, it reports occupancy flags for the active direction only.

Top module: `card_fifo_engine`

## Requirements
- R1: The FIFO holds up to 16 words of 32 bits in first-in first-out order, using wrapping read and write positions. `fifo_level_o` never exceeds 16.
- R2: In receive mode, the byte taken from the card at the k-th handshake of a word goes to bits [8k+7:8k]. When the counter hits zero after fewer than 4 bytes of a word, that partial word is still pushed, with its unused upper lanes set to zero.
- R3: In transmit mode, each FIFO word goes to the card as bytes [7:0], [15:8], [23:16], [31:24], in that order. Any bytes of a word left after the counter hits zero are dropped, and the word still leaves the FIFO.
- R4: A control strobe with `ctrl_en_i`=1 loads `byte_cnt_o` from the 16-bit `len_i`. Every card handshake lowers the counter by exactly one.
- R5: `card_rd_ready_o` is high only when all of these hold: the transfer is enabled, the direction is receive (`ctrl_dir_i`=1), the counter is nonzero and the FIFO holds fewer than 16 words.
- R6: `card_wr_valid_o` is high only when the transfer is enabled, the direction is transmit (0), the counter is nonzero, and a FIFO word or a leftover unpacked byte exists.
- R7: One cycle after the block is enabled with a zero counter, `data_end_o` and `block_end_o` go high. They stay high until `clr_end_i` is pulsed, and a new set wins over a clear in the same cycle.
- R8: When the block is enabled with a zero counter and an empty FIFO, `data_en_o` falls at the next clock. Both flag vectors are all zero whenever `data_en_o` is low.
- R9: The flag bit positions are: bit0 active; bit1 half (transmit: at most 8 words, receive: at least 8 words); bit2 full (16 words); bit3 empty (0 words); bit4 data available (1 or more words). Only `rx_flags_o` is nonzero in receive mode, and only `tx_flags_o` in transmit mode.
- R10: A host push is ignored in two cases: the FIFO is full, or the direction is receive. Either case gives a one-cycle `push_err_o` pulse in the following cycle.
- R11: `pop_data_o` shows the oldest word in receive mode and zero otherwise. A pop is ignored in two cases: the FIFO is empty, or the direction is transmit. Either case gives a one-cycle `pop_err_o` pulse, and `pop_data_o` reads zero in the empty case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_wr_i | input | 1 | Control strobe; latches enable and direction |
| ctrl_en_i | input | 1 | Enable value written by the strobe |
| ctrl_dir_i | input | 1 | Direction: 1 receive from card, 0 transmit to card |
| len_i | input | 16 | Transfer length in bytes, loaded when enabling |
| clr_end_i | input | 1 | Clears the end-of-transfer indications |
| push_valid_i | input | 1 | Host word push |
| push_data_i | input | 32 | Host word to push |
| pop_i | input | 1 | Host word pop |
| pop_data_o | output | 32 | Oldest FIFO word in receive mode, else zero |
| card_rd_valid_i | input | 1 | Card has a byte ready |
| card_rd_data_i | input | 8 | Byte from the card |
| card_rd_ready_o | output | 1 | Block accepts a card byte |
| card_wr_valid_o | output | 1 | Block offers a byte to the card |
| card_wr_data_o | output | 8 | Byte for the card |
| card_wr_ready_i | input | 1 | Card accepts the offered byte |
| data_en_o | output | 1 | Transfer enabled |
| byte_cnt_o | output | 16 | Bytes remaining |
| fifo_level_o | output | 5 | Words held in the FIFO |
| tx_flags_o | output | 5 | Transmit occupancy flags |
| rx_flags_o | output | 5 | Receive occupancy flags |
| data_end_o | output | 1 | Sticky counter-exhausted indication |
| block_end_o | output | 1 | Sticky block-complete indication |
| push_err_o | output | 1 | Rejected push pulse |
| pop_err_o | output | 1 | Rejected pop pulse |

## Verification
Two things can happen in the same clock: the packer pushes a word completed by a card byte while the host pops from the head, and in transmit mode the host pushes a word while the unpacker takes one. The receive case is provoked by letting the card stream continuously while a monitor pops every cycle that data is shown available. The transmit case is provoked by pushing while the card accepts bytes. A scoreboard judges word and byte order, and the level checks confirm that no word is lost or duplicated when these events coincide, including at exactly 16 words.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
  localparam int FLAG_W = 5;
  localparam logic DIR_RX = 1'b1;
  localparam logic DIR_TX = 1'b0;
endpackage

// File: rtl/cfe_fifo.sv
module cfe_fifo #(
  parameter int DEPTH = 16,
  parameter int DW = 32,
  localparam int PW = $clog2(DEPTH),
  localparam int LVLW = $clog2(DEPTH) + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            pop_i,
  output logic [DW-1:0]   rdata_o,
  output logic [LVLW-1:0] level_o,
  output logic            full_o,
  output logic            empty_o
);
  logic [DW-1:0]   mem_q [DEPTH];
  logic [PW-1:0]   wr_ptr_q, rd_ptr_q;
  logic [LVLW-1:0] level_q;
  logic            do_push, do_pop;

  assign full_o  = (level_q == LVLW'(DEPTH));
  assign empty_o = (level_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = empty_o ? '0 : mem_q[rd_ptr_q];
  assign level_o = level_q;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wrap_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= wrap_inc(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end
endmodule

// File: rtl/cfe_packer.sv
module cfe_packer #(
  parameter int DW = 32,
  parameter int BW = 8,
  localparam int NB = DW / BW,
  localparam int IW = $clog2(NB)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          take_i,
  input  logic          last_i,
  input  logic [BW-1:0] byte_i,
  output logic          push_o,
  output logic [DW-1:0] word_o
);
  logic [DW-1:0] acc_q;
  logic [IW-1:0] idx_q;

  // place the incoming byte in its lane, lowest lane first
  for (genvar l = 0; l < NB; l++) begin : g_lane
    assign word_o[l*BW +: BW] = (idx_q == IW'(l)) ? byte_i : acc_q[l*BW +: BW];
  end

  assign push_o = take_i && ((idx_q == IW'(NB - 1)) || last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (start_i) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (take_i) begin
      if (push_o) begin
        acc_q <= '0;
        idx_q <= '0;
      end else begin
        acc_q <= word_o;
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfe_unpacker.sv
module cfe_unpacker #(
  parameter int DW = 32,
  parameter int BW = 8,
  localparam int NB = DW / BW,
  localparam int IW = $clog2(NB)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] head_i,
  input  logic          head_valid_i,
  input  logic          take_i,
  input  logic          last_i,
  output logic          have_o,
  output logic [BW-1:0] byte_o,
  output logic          pop_o
);
  logic [DW-1:0] sh_q;
  logic [IW-1:0] rem_q;

  assign have_o = (rem_q != '0) || head_valid_i;
  assign byte_o = (rem_q != '0) ? sh_q[BW-1:0] : head_i[BW-1:0];
  // first byte comes straight from the head, so the word leaves the FIFO now
  assign pop_o  = take_i && (rem_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      rem_q <= '0;
    end else if (start_i) begin
      rem_q <= '0;
    end else if (take_i) begin
      if (last_i) begin
        rem_q <= '0;
      end else if (rem_q == '0) begin
        sh_q  <= head_i >> BW;
        rem_q <= IW'(NB - 1);
      end else begin
        sh_q  <= sh_q >> BW;
        rem_q <= rem_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfe_flags.sv
module cfe_flags #(
  parameter int DEPTH = 16,
  localparam int LVLW = $clog2(DEPTH) + 1
) (
  input  logic                      en_i,
  input  logic                      dir_i,
  input  logic [LVLW-1:0]           level_i,
  output logic [cfe_pkg::FLAG_W-1:0] tx_o,
  output logic [cfe_pkg::FLAG_W-1:0] rx_o
);
  logic avail, empty, full, le_half, ge_half;

  assign empty   = (level_i == '0);
  assign avail   = !empty;
  assign full    = (level_i == LVLW'(DEPTH));
  assign le_half = (level_i <= LVLW'(DEPTH / 2));
  assign ge_half = (level_i >= LVLW'(DEPTH / 2));

  assign tx_o = (en_i && dir_i == cfe_pkg::DIR_TX) ? {avail, empty, full, le_half, 1'b1} : '0;
  assign rx_o = (en_i && dir_i == cfe_pkg::DIR_RX) ? {avail, empty, full, ge_half, 1'b1} : '0;
endmodule

// File: rtl/card_fifo_engine.sv
module card_fifo_engine #(
  parameter int DEPTH = 16,
  parameter int DW = 32,
  parameter int BW = 8,
  parameter int LW = 16,
  localparam int LVLW = $clog2(DEPTH) + 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       ctrl_wr_i,
  input  logic                       ctrl_en_i,
  input  logic                       ctrl_dir_i,
  input  logic [LW-1:0]              len_i,
  input  logic                       clr_end_i,
  input  logic                       push_valid_i,
  input  logic [DW-1:0]              push_data_i,
  input  logic                       pop_i,
  output logic [DW-1:0]              pop_data_o,
  input  logic                       card_rd_valid_i,
  input  logic [BW-1:0]              card_rd_data_i,
  output logic                       card_rd_ready_o,
  output logic                       card_wr_valid_o,
  output logic [BW-1:0]              card_wr_data_o,
  input  logic                       card_wr_ready_i,
  output logic                       data_en_o,
  output logic [LW-1:0]              byte_cnt_o,
  output logic [LVLW-1:0]            fifo_level_o,
  output logic [cfe_pkg::FLAG_W-1:0] tx_flags_o,
  output logic [cfe_pkg::FLAG_W-1:0] rx_flags_o,
  output logic                       data_end_o,
  output logic                       block_end_o,
  output logic                       push_err_o,
  output logic                       pop_err_o
);
  import cfe_pkg::*;

  logic            en_q, dir_q, end_q, push_err_q, pop_err_q;
  logic [LW-1:0]   cnt_q;
  logic            cnt_nz, last_byte, start;
  logic            rd_take, wr_take;
  logic            fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [DW-1:0]   fifo_wdata, fifo_rdata;
  logic [LVLW-1:0] fifo_level;
  logic            pk_push, up_have, up_pop;
  logic [DW-1:0]   pk_word;
  logic            host_push_ok, host_pop_ok;

  assign cnt_nz    = (cnt_q != '0);
  assign last_byte = (cnt_q == LW'(1));
  assign start     = ctrl_wr_i && ctrl_en_i;

  assign card_rd_ready_o = en_q && (dir_q == DIR_RX) && cnt_nz && !fifo_full;
  assign rd_take         = card_rd_ready_o && card_rd_valid_i;
  assign card_wr_valid_o = en_q && (dir_q == DIR_TX) && cnt_nz && up_have;
  assign wr_take         = card_wr_valid_o && card_wr_ready_i;

  // host side owns the FIFO end that the engine does not use
  assign host_push_ok = push_valid_i && (dir_q == DIR_TX) && !fifo_full;
  assign host_pop_ok  = pop_i && (dir_q == DIR_RX) && !fifo_empty;

  assign fifo_push  = host_push_ok || pk_push;
  assign fifo_wdata = (dir_q == DIR_RX) ? pk_word : push_data_i;
  assign fifo_pop   = host_pop_ok || up_pop;

  cfe_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (fifo_push),
    .wdata_i (fifo_wdata),
    .pop_i   (fifo_pop),
    .rdata_o (fifo_rdata),
    .level_o (fifo_level),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  cfe_packer #(.DW(DW), .BW(BW)) u_pack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .take_i  (rd_take),
    .last_i  (last_byte),
    .byte_i  (card_rd_data_i),
    .push_o  (pk_push),
    .word_o  (pk_word)
  );

  cfe_unpacker #(.DW(DW), .BW(BW)) u_unpack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .head_i       (fifo_rdata),
    .head_valid_i (!fifo_empty),
    .take_i       (wr_take),
    .last_i       (last_byte),
    .have_o       (up_have),
    .byte_o       (card_wr_data_o),
    .pop_o        (up_pop)
  );

  cfe_flags #(.DEPTH(DEPTH)) u_flags (
    .en_i    (en_q),
    .dir_i   (dir_q),
    .level_i (fifo_level),
    .tx_o    (tx_flags_o),
    .rx_o    (rx_flags_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      dir_q      <= DIR_TX;
      cnt_q      <= '0;
      end_q      <= 1'b0;
      push_err_q <= 1'b0;
      pop_err_q  <= 1'b0;
    end else begin
      push_err_q <= push_valid_i && !host_push_ok;
      pop_err_q  <= pop_i && !host_pop_ok;
      if (ctrl_wr_i) begin
        en_q  <= ctrl_en_i;
        dir_q <= ctrl_dir_i;
        if (ctrl_en_i) cnt_q <= len_i;
      end else begin
        if (rd_take || wr_take) cnt_q <= cnt_q - 1'b1;
        if (en_q && !cnt_nz && fifo_empty) en_q <= 1'b0;
      end
      if (en_q && !cnt_nz) end_q <= 1'b1;
      else if (clr_end_i)  end_q <= 1'b0;
    end
  end

  assign pop_data_o   = (dir_q == DIR_RX) ? fifo_rdata : '0;
  assign data_en_o    = en_q;
  assign byte_cnt_o   = cnt_q;
  assign fifo_level_o = fifo_level;
  assign data_end_o   = end_q;
  assign block_end_o  = end_q;
  assign push_err_o   = push_err_q;
  assign pop_err_o    = pop_err_q;
endmodule

// File: rtl/cfe_checker.sv
module cfe_checker #(
  parameter int DEPTH = 16,
  parameter int DW = 32,
  parameter int BW = 8,
  parameter int LW = 16,
  localparam int LVLW = $clog2(DEPTH) + 1
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       ctrl_wr_i,
  input logic                       push_valid_i,
  input logic                       pop_i,
  input logic [DW-1:0]              pop_data_o,
  input logic                       card_rd_valid_i,
  input logic                       card_rd_ready_o,
  input logic                       card_wr_valid_o,
  input logic                       card_wr_ready_i,
  input logic                       data_en_o,
  input logic [LW-1:0]              byte_cnt_o,
  input logic [LVLW-1:0]            fifo_level_o,
  input logic [cfe_pkg::FLAG_W-1:0] tx_flags_o,
  input logic [cfe_pkg::FLAG_W-1:0] rx_flags_o,
  input logic                       data_end_o,
  input logic                       block_end_o,
  input logic                       push_err_o,
  input logic                       pop_err_o
);
  // R1
  level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_level_o <= LVLW'(DEPTH));

  // R4
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((card_rd_valid_i && card_rd_ready_o) || (card_wr_valid_o && card_wr_ready_i)) && !ctrl_wr_i)
    |=> byte_cnt_o == $past(byte_cnt_o) - 1'b1);

  // R5
  rd_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_rd_ready_o |-> (data_en_o && byte_cnt_o != '0 && fifo_level_o < LVLW'(DEPTH) && tx_flags_o == '0));

  // R6
  wr_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_wr_valid_o |-> (data_en_o && byte_cnt_o != '0 && rx_flags_o == '0));

  // R7
  end_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_en_o && byte_cnt_o == '0) |=> (data_end_o && block_end_o));

  // R8
  idle_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_en_o |-> (tx_flags_o == '0 && rx_flags_o == '0));

  // R9
  one_side_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_flags_o == '0) || (rx_flags_o == '0));

  // R10
  push_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_valid_i && fifo_level_o == LVLW'(DEPTH)) |=> push_err_o);

  // R11
  pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && fifo_level_o == '0) |-> pop_data_o == '0);

  // R11
  pop_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && fifo_level_o == '0) |=> pop_err_o);
endmodule

bind card_fifo_engine cfe_checker #(.DEPTH(DEPTH), .DW(DW), .BW(BW), .LW(LW)) u_chk (.*);

// File: tb/card_fifo_engine_bench.sv
`timescale 1ns/1ps
module card_fifo_engine_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctrl_wr_i = 0, ctrl_en_i = 0, ctrl_dir_i = 0, clr_end_i = 0;
  logic [15:0] len_i = '0;
  logic        push_valid_i = 0;
  logic [31:0] push_data_i = '0;
  logic        pop_i = 0;
  logic [31:0] pop_data_o;
  logic        card_rd_valid_i = 0;
  logic [7:0]  card_rd_data_i = '0;
  logic        card_rd_ready_o, card_wr_valid_o, card_wr_ready_i = 0;
  logic [7:0]  card_wr_data_o;
  logic        data_en_o, data_end_o, block_end_o, push_err_o, pop_err_o;
  logic [15:0] byte_cnt_o;
  logic [4:0]  fifo_level_o, tx_flags_o, rx_flags_o;

  int total = 0, bad = 0;
  logic [7:0]  src_q[$];
  logic [7:0]  exp_b[$];
  logic [31:0] exp_w[$];
  bit pop_en = 0, err_pop_req = 0, rd_hs = 0;

  always #2 clk = ~clk;

  card_fifo_engine u_card_fifo_engine (.clk_i(clk), .*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic ctrl(input bit en, input bit dir, input int len);
    step();
    ctrl_wr_i = 1; ctrl_en_i = en; ctrl_dir_i = dir; len_i = 16'(len);
    step();
    ctrl_wr_i = 0; ctrl_en_i = 0;
  endtask

  // driver: push a host word and queue the bytes the card should see
  task automatic push_word(input logic [31:0] w, input int nb);
    step();
    push_valid_i = 1; push_data_i = w;
    for (int i = 0; i < nb; i++) exp_b.push_back(w[8*i +: 8]);
    step();
    push_valid_i = 0;
  endtask

  // driver: queue card bytes and the words they pack into
  task automatic load_read(input int n, input int seed);
    logic [31:0] w = '0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] b = 8'(i * 7 + seed);
      src_q.push_back(b);
      w[8*(i%4) +: 8] = b;
      if (i % 4 == 3 || i == n - 1) begin
        exp_w.push_back(w);
        w = '0;
      end
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!data_en_o) break;
    end
  endtask

  task automatic wait_level(input int l);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (fifo_level_o == 5'(l)) break;
    end
  endtask

  // monitor and card model
  initial begin
    forever begin
      @(negedge clk);
      if (card_wr_valid_o && card_wr_ready_i) begin
        if (exp_b.size() == 0) chk("R3 unexpected byte", 32'(card_wr_data_o), 32'hx);
        else chk("R3 byte order", 32'(card_wr_data_o), 32'(exp_b.pop_front()));
      end
      rd_hs = card_rd_valid_i && card_rd_ready_o;
      pop_i = err_pop_req || (pop_en && rx_flags_o[4]);
      if (pop_en && rx_flags_o[4]) begin
        if (exp_w.size() == 0) chk("R2 unexpected word", pop_data_o, 32'hx);
        else chk("R2 word packing", pop_data_o, exp_w.pop_front());
      end
      @(posedge clk); #1;
      if (rd_hs && src_q.size() > 0) void'(src_q.pop_front());
      card_rd_valid_i = (src_q.size() > 0);
      card_rd_data_i  = (src_q.size() > 0) ? src_q[0] : 8'h00;
    end
  end

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    @(negedge clk);
    chk("R8 reset enable", 32'(data_en_o), 0);
    chk("R1 reset level", 32'(fifo_level_o), 0);
    chk("R8 reset flags", {22'b0, tx_flags_o, rx_flags_o}, 0);
    chk("R7 reset end", 32'(data_end_o), 0);
    chk("R11 reset pop data", pop_data_o, 0);

    // R7 R8: zero length
    ctrl(1, 1, 0);
    @(negedge clk);
    chk("R8 enabled zero length", 32'(data_en_o), 1);
    @(negedge clk);
    chk("R8 auto disable", 32'(data_en_o), 0);
    chk("R7 data end set", {30'b0, data_end_o, block_end_o}, 3);
    step(); clr_end_i = 1; step(); clr_end_i = 0;
    @(negedge clk);
    chk("R7 end cleared", {30'b0, data_end_o, block_end_o}, 0);

    // receive fill to full, then drain
    load_read(80, 3);
    ctrl(1, 1, 80);
    wait_level(8);
    chk("R9 rx half full", 32'(rx_flags_o), 32'b10011);
    chk("R9 tx silent", 32'(tx_flags_o), 0);
    wait_level(16);
    repeat (3) @(negedge clk);
    chk("R5 ready low when full", 32'(card_rd_ready_o), 0);
    chk("R9 rx full", 32'(rx_flags_o), 32'b10111);
    chk("R4 count after 64", 32'(byte_cnt_o), 16);
    push_word(32'hDEADBEEF, 0);
    @(negedge clk);
    chk("R10 push in receive", 32'(push_err_o), 1);
    chk("R1 level held", 32'(fifo_level_o), 16);
    @(negedge clk);
    chk("R10 pulse width", 32'(push_err_o), 0);
    pop_en = 1;
    wait_idle();
    pop_en = 0;
    chk("R2 all words seen", 32'(exp_w.size()), 0);
    chk("R7 end after receive", 32'(data_end_o), 1);
    chk("R8 flags idle", {22'b0, tx_flags_o, rx_flags_o}, 0);
    step(); err_pop_req = 1; step(); err_pop_req = 0;
    @(negedge clk);
    chk("R11 pop empty error", 32'(pop_err_o), 1);
    chk("R11 pop empty data", pop_data_o, 0);

    // receive partial word
    load_read(6, 40);
    pop_en = 1;
    ctrl(1, 1, 6);
    wait_idle();
    pop_en = 0;
    chk("R2 partial word", 32'(exp_w.size()), 0);

    // transmit: fill, flags, errors, drain
    ctrl(0, 0, 0);
    for (int i = 0; i < 8; i++)
      push_word({8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)} ^ 32'h5A5A5A5A, 4);
    ctrl(1, 0, 64);
    @(negedge clk);
    chk("R9 tx half empty", 32'(tx_flags_o), 32'b10011);
    chk("R9 rx silent", 32'(rx_flags_o), 0);
    chk("R4 count load", 32'(byte_cnt_o), 64);
    chk("R6 valid with data", 32'(card_wr_valid_o), 1);
    for (int i = 8; i < 16; i++)
      push_word({8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)} ^ 32'hA5A5A5A5, 4);
    @(negedge clk);
    chk("R9 tx full", 32'(tx_flags_o), 32'b10101);
    push_word(32'h12345678, 0);
    @(negedge clk);
    chk("R10 push when full", 32'(push_err_o), 1);
    chk("R1 level at 16", 32'(fifo_level_o), 16);
    step(); err_pop_req = 1; step(); err_pop_req = 0;
    @(negedge clk);
    chk("R11 pop in transmit", 32'(pop_err_o), 1);
    chk("R11 level unchanged", 32'(fifo_level_o), 16);
    step(); card_wr_ready_i = 1;
    wait_idle();
    chk("R3 all bytes seen", 32'(exp_b.size()), 0);
    chk("R4 count zero", 32'(byte_cnt_o), 0);

    // transmit with dropped tail bytes
    for (int i = 0; i < 5; i++) push_word(32'h01020304 * (i + 1), (i < 4) ? 4 : 2);
    ctrl(1, 0, 18);
    wait_idle();
    chk("R3 tail dropped, FIFO empty", 32'(fifo_level_o), 0);
    chk("R3 partial bytes", 32'(exp_b.size()), 0);

    // transmit starved
    ctrl(1, 0, 4);
    repeat (3) @(negedge clk);
    chk("R6 no valid when empty", 32'(card_wr_valid_o), 0);
    chk("R8 stays enabled", 32'(data_en_o), 1);
    push_word(32'hA1B2C3D4, 4);
    wait_idle();
    chk("R3 late word", 32'(exp_b.size()), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule